// File: doc/BRIEF.md
# Online Soft/Hard Error Classifier and Spare-Word Remapper

This controller sits between a host port and a word-wide memory protected by a single-error-correct, double-error-detect code. On every host read it corrects at most one flipped bit in the same cycle. When a correctable error appears, it takes the memory away from the host for a short, fixed sequence. It writes the corrected word back, reads it again, and uses the second read to decide whether the error was transient or a permanent cell fault.

A permanent fault is retired. The address is entered into a small associative table, and the corrected word is stored in an external spare-word array. From then on, reads and writes to that address go to the spare entry combinationally, with no extra cycle. The spare entry still carries the full code, so a later soft error in that word can still be corrected. A spare entry that develops a permanent fault of its own is marked unusable, and its data moves to the next free entry. An uncorrectable read and an exhausted spare pool each raise their own sticky flag.

Top module: `ecc_repair_ctrl`

## Requirements
- R1: After reset, `busy_o`, `uncorr_o` and `overflow_o` are 0, and no spare entry is in use.
- R2: Codeword layout and read path. The stored codeword has 22 bits.
  - Bit 0 is the overall parity.
  - Bits 1, 2, 4, 8 and 16 are Hamming checks over the positions whose index has that bit set.
  - The 16 data bits fill positions 3, 5-7, 9-15 and 17-21 from the least significant bit upward.
  - A host read (`req_i`=1, `we_i`=0 while idle) returns the corrected data on `rdata_o` in the same cycle.
- R3: A host write while idle stores the encoded word in the same cycle. It goes to the spare array if the address is remapped, and to the main memory otherwise.
- R4: A read with one bit in error and a clean re-read is soft. `busy_o` is high for exactly 4 cycles after the read edge. The corrected word is written back to where it was read, and no spare entry is written.
- R5: A read with one bit in error whose re-read still fails is hard. `busy_o` is high for exactly 6 cycles. The corrected word is written to the lowest-numbered free spare entry, and that entry is bound to the address.
- R6: A read of a remapped address is served from its spare entry in the same cycle, with `spare_idx_o` showing the entry. At most one usable entry matches any address.
- R7: A hard fault found in a spare entry marks that entry faulty forever. The data moves to the lowest free entry, and a faulty entry is never served or reallocated.
- R8: A read that detects two bit errors sets `uncorr_o`, which stays set until reset. It starts no identification sequence.
- R9: A hard fault with no free spare entry sets the sticky `overflow_o`. `busy_o` is high for exactly 5 cycles, nothing is written to the spare array, and the word stays in main memory, still corrected on read.
- R10: Host requests made while `busy_o` is high are ignored and change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | AW | Host word address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Corrected read data |
| busy_o | output | 1 | Identification or repair in progress; host held off |
| mem_addr_o | output | AW | Main memory address |
| mem_we_o | output | 1 | Main memory write enable |
| mem_wdata_o | output | 22 | Main memory write codeword |
| mem_rdata_i | input | 22 | Main memory read codeword (combinational read) |
| spare_idx_o | output | SW | Spare array entry index |
| spare_we_o | output | 1 | Spare array write enable |
| spare_wdata_o | output | 22 | Spare array write codeword |
| spare_rdata_i | input | 22 | Spare array read codeword (combinational read) |
| uncorr_o | output | 1 | Sticky double-error flag |
| overflow_o | output | 1 | Sticky spare-pool exhaustion flag |

## Verification
Read data and remap selection are due in the same cycle as the request. The bench samples them one time unit after driving the inputs at the falling edge, before the capturing rising edge. `busy_o` rises one edge after the read. It then stays high for 4, 5 or 6 cycles for the soft, overflow and hard outcomes. A per-clock monitor compares it at every falling edge against a countdown that the bench loads at that edge. The same monitor counts spare-array writes and records the last index written. Each scenario compares those counts once the countdown has run out.

// File: rtl/ecc_repair_pkg.sv
package ecc_repair_pkg;
  localparam int DATA_W = 16;
  localparam int CW_W   = 22;
  localparam int SYN_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITEBACK, ST_REREAD, ST_CHECK, ST_ALLOC, ST_SPARE_WRITE, ST_DONE
  } phase_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              single;
    logic              dbl;
  } dec_t;

  function automatic logic [CW_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int i = 1; i < CW_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        cw[i] = d[k];
        k++;
      end
    end
    for (int p = 0; p < SYN_W; p++) begin
      logic x;
      x = 1'b0;
      for (int i = 1; i < CW_W; i++)
        if (((i >> p) & 1) == 1 && i != (1 << p)) x ^= cw[i];
      cw[1 << p] = x;
    end
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic dec_t secded_dec(input logic [CW_W-1:0] cw_in);
    logic [CW_W-1:0] cw;
    logic [SYN_W-1:0] syn;
    logic overall;
    dec_t r;
    int k;
    cw  = cw_in;
    syn = '0;
    for (int i = 1; i < CW_W; i++)
      if (cw[i]) syn ^= SYN_W'(i);
    overall  = ^cw;
    r.single = overall && (int'(syn) < CW_W);
    r.dbl    = (!overall && syn != '0) || (overall && int'(syn) >= CW_W);
    if (r.single && syn != '0) cw[syn] = ~cw[syn];
    r.data = '0;
    k = 0;
    for (int i = 1; i < CW_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        r.data[k] = cw[i];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/secded_codec.sv
module secded_codec
  import ecc_repair_pkg::*;
(
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CW_W-1:0]   enc_cw_o,
  input  logic [CW_W-1:0]   dec_cw_i,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              single_o,
  output logic              double_o
);
  dec_t dec;

  always_comb begin
    enc_cw_o   = secded_enc(enc_data_i);
    dec        = secded_dec(dec_cw_i);
    dec_data_o = dec.data;
    single_o   = dec.single;
    double_o   = dec.dbl;
  end
endmodule

// File: rtl/spare_map.sv
module spare_map #(
  parameter int AW      = 12,
  parameter int ENTRIES = 8,
  localparam int SW     = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] lookup_addr_i,
  output logic          hit_o,
  output logic [SW-1:0] hit_idx_o,
  output logic          free_any_o,
  output logic [SW-1:0] free_idx_o,
  input  logic          alloc_en_i,
  input  logic [AW-1:0] alloc_tag_i,
  input  logic          mark_en_i,
  input  logic [SW-1:0] mark_idx_i
);
  logic [ENTRIES-1:0] valid_q, faulty_q, hit_vec;
  logic [AW-1:0]      tag_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g]  <= 1'b0;
        faulty_q[g] <= 1'b0;
        tag_q[g]    <= '0;
      end else begin
        if (alloc_en_i && free_idx_o == SW'(g)) begin
          valid_q[g] <= 1'b1;
          tag_q[g]   <= alloc_tag_i;
        end
        if (mark_en_i && mark_idx_i == SW'(g)) faulty_q[g] <= 1'b1;
      end
    end
    assign hit_vec[g] = valid_q[g] && !faulty_q[g] && tag_q[g] == lookup_addr_i;

    // R7: a retired spare entry never returns to service
    a_r7_faulty_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      faulty_q[g] |=> faulty_q[g]);
  end

  always_comb begin
    hit_o      = 1'b0;
    hit_idx_o  = '0;
    free_any_o = 1'b0;
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = SW'(i);
      end
      if (!valid_q[i]) begin
        free_any_o = 1'b1;
        free_idx_o = SW'(i);
      end
    end
  end

  a_r6_unique_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  a_r5_alloc_target_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |=> valid_q[$past(free_idx_o)] && tag_q[$past(free_idx_o)] == $past(alloc_tag_i));
endmodule

// File: rtl/repair_fsm.sv
module repair_fsm
  import ecc_repair_pkg::*;
#(
  parameter int AW      = 12,
  parameter int ENTRIES = 8,
  localparam int SW     = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              hit_i,
  input  logic [SW-1:0]     hit_idx_i,
  input  logic              single_i,
  input  logic              double_i,
  input  logic [DATA_W-1:0] dec_data_i,
  input  logic              free_any_i,
  input  logic [SW-1:0]     free_idx_i,
  output phase_e            phase_o,
  output logic [AW-1:0]     cap_addr_o,
  output logic [DATA_W-1:0] cap_data_o,
  output logic              cap_in_spare_o,
  output logic [SW-1:0]     cap_idx_o,
  output logic [SW-1:0]     alloc_idx_o,
  output logic              alloc_en_o,
  output logic              mark_en_o,
  output logic              uncorr_o,
  output logic              overflow_o
);
  phase_e phase_q;
  logic   reread_bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q        <= ST_IDLE;
      cap_addr_o     <= '0;
      cap_data_o     <= '0;
      cap_in_spare_o <= 1'b0;
      cap_idx_o      <= '0;
      alloc_idx_o    <= '0;
      reread_bad_q   <= 1'b0;
      uncorr_o       <= 1'b0;
      overflow_o     <= 1'b0;
    end else begin
      unique case (phase_q)
        ST_IDLE: begin
          if (host_rd_i && double_i) begin
            uncorr_o <= 1'b1;
          end else if (host_rd_i && single_i) begin
            cap_addr_o     <= addr_i;
            cap_data_o     <= dec_data_i;
            cap_in_spare_o <= hit_i;
            cap_idx_o      <= hit_idx_i;
            phase_q        <= ST_WRITEBACK;
          end
        end
        ST_WRITEBACK: phase_q <= ST_REREAD;
        ST_REREAD: begin
          reread_bad_q <= single_i || double_i;
          phase_q      <= ST_CHECK;
        end
        ST_CHECK: phase_q <= reread_bad_q ? ST_ALLOC : ST_DONE;
        ST_ALLOC: begin
          if (free_any_i) begin
            alloc_idx_o <= free_idx_i;
            phase_q     <= ST_SPARE_WRITE;
          end else begin
            overflow_o <= 1'b1;
            phase_q    <= ST_DONE;
          end
        end
        ST_SPARE_WRITE: phase_q <= ST_DONE;
        ST_DONE:        phase_q <= ST_IDLE;
        default:        phase_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign alloc_en_o = (phase_q == ST_ALLOC) && free_any_i;
  assign mark_en_o  = (phase_q == ST_CHECK) && reread_bad_q && cap_in_spare_o;

  a_r4_writeback_then_reread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == ST_WRITEBACK |=> phase_q == ST_REREAD);
  a_r4_clean_reread_is_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_CHECK && !reread_bad_q) |=> phase_q == ST_DONE);
  a_r8_uncorr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |=> uncorr_o);
  a_r9_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  a_r9_overflow_skips_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> phase_q == ST_DONE);
endmodule

// File: rtl/ecc_repair_ctrl.sv
module ecc_repair_ctrl
  import ecc_repair_pkg::*;
#(
  parameter int AW     = 12,
  parameter int SPARES = 8,
  localparam int SW    = $clog2(SPARES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic [CW_W-1:0]   mem_wdata_o,
  input  logic [CW_W-1:0]   mem_rdata_i,
  output logic [SW-1:0]     spare_idx_o,
  output logic              spare_we_o,
  output logic [CW_W-1:0]   spare_wdata_o,
  input  logic [CW_W-1:0]   spare_rdata_i,
  output logic              uncorr_o,
  output logic              overflow_o
);
  phase_e            phase;
  logic              idle, host_rd, host_wr, rd_spare;
  logic              hit, free_any, alloc_en, mark_en;
  logic [SW-1:0]     hit_idx, free_idx, cap_idx, alloc_idx;
  logic [AW-1:0]     cap_addr;
  logic [DATA_W-1:0] cap_data, dec_data;
  logic              cap_in_spare, single, dbl;
  logic [CW_W-1:0]   enc_cw, raw_cw;

  assign idle     = phase == ST_IDLE;
  assign busy_o   = !idle;
  assign host_rd  = idle && req_i && !we_i;
  assign host_wr  = idle && req_i && we_i;
  assign rd_spare = idle ? hit : cap_in_spare;
  assign raw_cw   = rd_spare ? spare_rdata_i : mem_rdata_i;

  secded_codec u_codec (
    .enc_data_i (idle ? wdata_i : cap_data),
    .enc_cw_o   (enc_cw),
    .dec_cw_i   (raw_cw),
    .dec_data_o (dec_data),
    .single_o   (single),
    .double_o   (dbl)
  );

  spare_map #(.AW(AW), .ENTRIES(SPARES)) u_map (
    .clk_i, .rst_ni,
    .lookup_addr_i (addr_i),
    .hit_o         (hit),
    .hit_idx_o     (hit_idx),
    .free_any_o    (free_any),
    .free_idx_o    (free_idx),
    .alloc_en_i    (alloc_en),
    .alloc_tag_i   (cap_addr),
    .mark_en_i     (mark_en),
    .mark_idx_i    (cap_idx)
  );

  repair_fsm #(.AW(AW), .ENTRIES(SPARES)) u_fsm (
    .clk_i, .rst_ni,
    .host_rd_i      (host_rd),
    .addr_i         (addr_i),
    .hit_i          (hit),
    .hit_idx_i      (hit_idx),
    .single_i       (single),
    .double_i       (dbl),
    .dec_data_i     (dec_data),
    .free_any_i     (free_any),
    .free_idx_i     (free_idx),
    .phase_o        (phase),
    .cap_addr_o     (cap_addr),
    .cap_data_o     (cap_data),
    .cap_in_spare_o (cap_in_spare),
    .cap_idx_o      (cap_idx),
    .alloc_idx_o    (alloc_idx),
    .alloc_en_o     (alloc_en),
    .mark_en_o      (mark_en),
    .uncorr_o       (uncorr_o),
    .overflow_o     (overflow_o)
  );

  assign rdata_o       = dec_data;
  assign mem_addr_o    = idle ? addr_i : cap_addr;
  assign mem_wdata_o   = enc_cw;
  assign spare_wdata_o = enc_cw;
  assign mem_we_o      = (host_wr && !hit) || (phase == ST_WRITEBACK && !cap_in_spare);
  assign spare_idx_o   = idle ? hit_idx : (phase == ST_SPARE_WRITE ? alloc_idx : cap_idx);
  assign spare_we_o    = (host_wr && hit) || (phase == ST_WRITEBACK && cap_in_spare)
                         || phase == ST_SPARE_WRITE;

  a_r3_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && spare_we_o));
  a_r10_busy_holds_address: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));
endmodule

// File: tb/sim_ecc_repair_ctrl.sv
module sim_ecc_repair_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int NS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic busy, mem_we, spare_we, uncorr, overflow;
  logic [AW-1:0] mem_addr;
  logic [21:0] mem_wdata, mem_rdata, spare_wdata, spare_rdata;
  logic [2:0] spare_idx;

  logic [21:0] mem [1 << AW];
  logic [21:0] mstk [1 << AW];
  logic [21:0] mval [1 << AW];
  logic [21:0] spr [NS];
  logic [21:0] sstk [NS];
  logic [21:0] sval [NS];

  int checks = 0, fails = 0, busy_left = 0, sw_cnt = 0, last_sw = -1;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ecc_repair_ctrl #(.AW(AW), .SPARES(NS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .spare_idx_o(spare_idx), .spare_we_o(spare_we),
    .spare_wdata_o(spare_wdata), .spare_rdata_i(spare_rdata),
    .uncorr_o(uncorr), .overflow_o(overflow)
  );

  assign mem_rdata   = (mem[mem_addr] & ~mstk[mem_addr]) | (mval[mem_addr] & mstk[mem_addr]);
  assign spare_rdata = (spr[spare_idx] & ~sstk[spare_idx]) | (sval[spare_idx] & sstk[spare_idx]);

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (spare_we) spr[spare_idx] <= spare_wdata;
  end

  // code per R2: check bits are the XOR of the indices of the set data positions
  function automatic logic [21:0] tb_enc(input logic [15:0] d);
    logic [21:0] cw = '0;
    logic [4:0] s = '0;
    int k = 0;
    for (int i = 1; i < 22; i++) begin
      if (i != 1 && i != 2 && i != 4 && i != 8 && i != 16) begin
        cw[i] = d[k];
        if (d[k]) s ^= 5'(i);
        k++;
      end
    end
    for (int p = 0; p < 5; p++) cw[1 << p] = s[p];
    cw[0] = ^cw[21:1];
    return cw;
  endfunction

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // per-clock reference: busy_o follows the countdown loaded after each read
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4/R5/R9 busy", 32'(busy), 32'(busy_left > 0));
      if (busy_left > 0) busy_left--;
      if (spare_we) begin
        sw_cnt++;
        last_sw = int'(spare_idx);
      end
    end
  end

  task automatic host_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 0; we = 0;
  endtask

  // read, check data same cycle, then expect busy for nbusy cycles
  task automatic host_read(input logic [AW-1:0] a, input logic [15:0] exp_d,
                           input int nbusy, input string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 chk(tag, 32'(rdata), 32'(exp_d));
    @(posedge clk);
    busy_left = nbusy;
    #1 req = 0;
    repeat (nbusy + 1) @(negedge clk);
  endtask

  task automatic stick_main(input logic [AW-1:0] a, input int b);
    mstk[a][b] = 1'b1;
    mval[a][b] = ~mem[a][b];
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int base;
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = '0; mstk[i] = '0; mval[i] = '0;
    end
    for (int i = 0; i < NS; i++) begin
      spr[i] = '0; sstk[i] = '0; sval[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 uncorr", 32'(uncorr), 0);
    chk("R1 overflow", 32'(overflow), 0);
    rst_n = 1;

    // R3 encode on write, R2 clean reads
    host_write(12'h010, 16'hA5C3);
    chk("R3 main codeword", 32'(mem[12'h010]), 32'(tb_enc(16'hA5C3)));
    host_write(12'h011, 16'h0001);
    host_write(12'h012, 16'hFFFF);
    host_read(12'h010, 16'hA5C3, 0, "R2 clean read");
    host_read(12'h011, 16'h0001, 0, "R2 clean read");
    host_read(12'h012, 16'hFFFF, 0, "R2 clean read");
    // R2: corrected in the same cycle, one data bit and the overall parity bit
    mem[12'h011][3] = ~mem[12'h011][3];
    mem[12'h012][0] = ~mem[12'h012][0];
    base = sw_cnt;
    host_read(12'h011, 16'h0001, 4, "R2 corrected data");
    host_read(12'h012, 16'hFFFF, 4, "R2 corrected parity");
    // R4 soft: written back, no spare use
    chk("R4 no spare write", 32'(sw_cnt - base), 0);
    chk("R4 written back", 32'(mem[12'h011]), 32'(tb_enc(16'h0001)));
    host_read(12'h011, 16'h0001, 0, "R4 clean after soft");

    // R10: write while busy ignored
    host_write(12'h020, 16'h1234);
    mem[12'h010][9] = ~mem[12'h010][9];
    @(negedge clk);
    req = 1; we = 0; addr = 12'h010;
    @(posedge clk);
    busy_left = 4;
    #1 we = 1; addr = 12'h020; wdata = 16'hDEAD;
    repeat (3) @(negedge clk);
    req = 0; we = 0;
    repeat (3) @(negedge clk);
    host_read(12'h020, 16'h1234, 0, "R10 write during busy ignored");

    // R5 hard fault in main -> spare 0
    host_write(12'h030, 16'h5A5A);
    stick_main(12'h030, 7);
    base = sw_cnt;
    host_read(12'h030, 16'h5A5A, 6, "R5 hard read corrected");
    chk("R5 one spare write", 32'(sw_cnt - base), 1);
    chk("R5 lowest free entry", 32'(last_sw), 0);
    chk("R5 spare codeword", 32'(spr[0]), 32'(tb_enc(16'h5A5A)));
    // R6 served from spare with no extra cycle
    @(negedge clk);
    addr = 12'h030; #1;
    chk("R6 remap index", 32'(spare_idx), 0);
    host_read(12'h030, 16'h5A5A, 0, "R6 read from spare");
    // R3 write to remapped address goes to spare
    @(negedge clk);
    req = 1; we = 1; addr = 12'h030; wdata = 16'h0F0F;
    #1;
    chk("R3 remapped write to spare", 32'(spare_we), 1);
    chk("R3 remapped write not main", 32'(mem_we), 0);
    @(posedge clk);
    #1 req = 0; we = 0;
    host_read(12'h030, 16'h0F0F, 0, "R3 read back remapped write");

    // second hard fault -> spare 1
    host_write(12'h040, 16'hC0DE);
    stick_main(12'h040, 12);
    host_read(12'h040, 16'hC0DE, 6, "R5 second hard fault");
    chk("R5 entry 1", 32'(last_sw), 1);

    // R7 spare entry 1 goes bad -> moved to entry 2
    sstk[1][5] = 1'b1;
    sval[1][5] = ~spr[1][5];
    base = sw_cnt;
    host_read(12'h040, 16'hC0DE, 6, "R7 spare hard fault corrected");
    chk("R7 writes wb+move", 32'(sw_cnt - base), 2);
    chk("R7 moved to entry 2", 32'(last_sw), 2);
    @(negedge clk);
    addr = 12'h040; #1;
    chk("R7 served from entry 2", 32'(spare_idx), 2);
    host_read(12'h040, 16'hC0DE, 0, "R7 clean after move");

    // R8 double error
    host_write(12'h050, 16'h7777);
    mem[12'h050][3] = ~mem[12'h050][3];
    mem[12'h050][6] = ~mem[12'h050][6];
    @(negedge clk);
    req = 1; we = 0; addr = 12'h050;
    @(posedge clk);
    #1 req = 0;
    @(negedge clk);
    chk("R8 uncorr set", 32'(uncorr), 1);
    repeat (4) @(negedge clk);
    chk("R8 uncorr sticky", 32'(uncorr), 1);

    // fill entries 3..7 (entry 1 faulty never reused)
    for (int k = 0; k < 5; k++) begin
      host_write(12'h100 + 12'(k), 16'(16'h1000 + k));
      stick_main(12'h100 + 12'(k), 2 + k);
      host_read(12'h100 + 12'(k), 16'(16'h1000 + k), 6, "R7 fill skips faulty");
      chk("R7 fill entry", 32'(last_sw), 32'(3 + k));
    end

    // R9 overflow
    host_write(12'h200, 16'hBEEF);
    stick_main(12'h200, 20);
    base = sw_cnt;
    host_read(12'h200, 16'hBEEF, 5, "R9 overflow read corrected");
    chk("R9 overflow set", 32'(overflow), 1);
    chk("R9 no spare write", 32'(sw_cnt - base), 0);
    host_read(12'h200, 16'hBEEF, 5, "R9 still corrected");
    chk("R9 overflow sticky", 32'(overflow), 1);
    host_read(12'h030, 16'h0F0F, 0, "R6 earlier remap intact");

    finish_run();
  end
endmodule